// File: doc/BRIEF.md
# Modbus RTU CRC-16 Frame Engine

This block generates and verifies the 16-bit check code that protects Modbus RTU frames. It receives message bytes one at a time on a valid/ready interface and folds each byte into a 16-bit register. The register is preset to all ones at the start of each frame. Each byte takes one bit step per clock, and the block stays busy until all eight steps of a byte are done. Only the eight data bits of a character reach the block. Start, stop and parity bits are removed upstream.

In transmit use, the sender reads the two check bytes after the last payload byte and appends them to the frame, low byte first. In receive use, the whole frame is fed through the engine, including the two received check bytes. An end-of-frame strobe then compares the residue with zero. A zero residue raises the match flag; any other value raises the error flag. No copy of the received check field has to be kept.

Top module: `crc16_frame_engine`

## Requirements
- R1: Asserting `sof_i` loads the register with 0xFFFF on the next edge. It abandons any byte in progress, so `busy_o` reads 0 afterwards, and it clears `match_o`, `error_o` and `done_o`. `sof_i` has priority over every other input.
- R2: A byte is accepted on an edge where `byte_valid_i` and `byte_ready_o` are both 1. `byte_ready_o` is 1 only when the engine is not busy and neither `sof_i` nor `eof_i` is asserted. On the accept edge the byte is XORed into bits 7:0 of the register, and the first bit step is then applied to the result.
- R3: One bit step shifts the register right by one place with a zero entering bit 15. If the bit shifted out of bit 0 was 1, the step then XORs the register with 0xA001. For example, from 0xFFFF, accepting 0xFF gives 0x7F80.
- R4: Each byte receives exactly eight bit steps on eight consecutive edges. `busy_o` is 1 for the seven cycles that follow the accept edge. A new byte can be accepted eight cycles after the previous one.
- R5: A byte offered while `busy_o` is 1 is ignored and does not change the register.
- R6: Starting from 0xFFFF, the ASCII bytes "123456789" produce 0x4B37 in `crc_o`. The frame 01 03 00 00 00 01 produces 0x0A84.
- R7: `chk_first_o` carries `crc_o[7:0]`, which is transmitted first, and `chk_second_o` carries `crc_o[15:8]`.
- R8: When `eof_i` is asserted while the engine is idle, `done_o` pulses for one cycle after the edge. If `rx_mode_i` is 1, `match_o` is set when the register is zero and `error_o` is set otherwise. Both flags hold until the next accepted end-of-frame or `sof_i`.
- R9: With `rx_mode_i` at 0, an end-of-frame still pulses `done_o` but sets neither `match_o` nor `error_o`.
- R10: An `eof_i` asserted while `busy_o` is 1 is ignored: `done_o` does not pulse and the flags keep their values.
- R11: After reset, `crc_o` is 0xFFFF, `busy_o`, `done_o`, `match_o` and `error_o` are 0, and `byte_ready_o` is 1 when no strobe is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sof_i | input | 1 | Start of frame: preset the register and clear the flags |
| byte_valid_i | input | 1 | A data byte is offered |
| byte_data_i | input | 8 | Data byte (the eight data bits only) |
| byte_ready_o | output | 1 | The engine can take a byte this cycle |
| eof_i | input | 1 | End-of-frame strobe |
| rx_mode_i | input | 1 | 1: check the frame at end of frame; 0: generate only |
| crc_o | output | 16 | Running register value |
| chk_first_o | output | 8 | Check byte sent first (low half) |
| chk_second_o | output | 8 | Check byte sent second (high half) |
| busy_o | output | 1 | Bit steps of a byte are still pending |
| done_o | output | 1 | One-cycle pulse after an accepted end of frame |
| match_o | output | 1 | Receive check found a zero residue |
| error_o | output | 1 | Receive check found a nonzero residue |

## Verification
The assertions check the following on every cycle:
- the preset after `sof_i`;
- the falling step count while busy;
- the busy flag that follows an accept;
- a held register while idle;
- that match and error never appear together;
- that no end-of-frame result is produced while busy or in transmit mode.

Only the bench scenarios can show that the arithmetic is correct. They cover the known-answer strings, the low-byte-first order of the check bytes, the zero residue of a valid received frame, the error flag on a corrupted frame, and the recovery when a byte is abandoned part-way through.

// File: rtl/crc16_pkg.sv
package crc16_pkg;
    localparam int unsigned CRC_W  = 16;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned NBYTES = CRC_W / BYTE_W;
    localparam int unsigned CNT_W  = $clog2(BYTE_W);

    typedef logic [CRC_W-1:0]  crc_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [CNT_W-1:0]  cnt_t;

    // One reflected bit step: shift toward bit 0, fold the polynomial
    // back in when the departing bit was set.
    function automatic crc_t crc_step(input crc_t r, input crc_t poly);
        crc_t sh;
        sh = r >> 1;
        return r[0] ? (sh ^ poly) : sh;
    endfunction
endpackage

// File: rtl/crc16_shift_unit.sv
module crc16_shift_unit
    import crc16_pkg::*;
#(
    parameter crc_t POLY = 16'hA001,
    parameter crc_t INIT = 16'hFFFF
) (
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  load_init_i,
    input  logic  accept_i,
    input  byte_t data_i,
    input  logic  step_en_i,
    output crc_t  crc_o,
    output logic  zero_o
);
    typedef struct packed {
        crc_t crc;
    } sh_state_t;

    sh_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_init_i) begin
            st_d.crc = INIT;
        end else if (accept_i) begin
            st_d.crc = crc_step(st_q.crc ^ crc_t'(data_i), POLY);
        end else if (step_en_i) begin
            st_d.crc = crc_step(st_q.crc, POLY);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '{crc: INIT};
        else         st_q <= st_d;
    end

    assign crc_o  = st_q.crc;
    assign zero_o = (st_q.crc == '0);

    // R1
    init_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        load_init_i |=> (crc_o == INIT));
endmodule

// File: rtl/crc16_frame_ctrl.sv
module crc16_frame_ctrl
    import crc16_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic sof_i,
    input  logic valid_i,
    input  logic eof_i,
    input  logic rx_mode_i,
    input  logic crc_zero_i,
    output logic ready_o,
    output logic accept_o,
    output logic busy_o,
    output logic done_o,
    output logic match_o,
    output logic error_o
);
    typedef struct packed {
        cnt_t cnt;
        logic done;
        logic match;
        logic err;
    } ctl_state_t;

    ctl_state_t st_d, st_q;
    logic busy;

    assign busy     = (st_q.cnt != '0);
    assign ready_o  = !busy && !sof_i && !eof_i;
    assign accept_o = ready_o && valid_i;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (sof_i) begin
            st_d.cnt   = '0;
            st_d.match = 1'b0;
            st_d.err   = 1'b0;
        end else if (busy) begin
            st_d.cnt = st_q.cnt - cnt_t'(1);
        end else if (eof_i) begin
            st_d.done  = 1'b1;
            st_d.match = rx_mode_i && crc_zero_i;
            st_d.err   = rx_mode_i && !crc_zero_i;
        end else if (valid_i) begin
            st_d.cnt = cnt_t'(BYTE_W - 1);
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign busy_o  = busy;
    assign done_o  = st_q.done;
    assign match_o = st_q.match;
    assign error_o = st_q.err;

    // R2
    accept_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        accept_o |=> busy_o);

    // R4
    step_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && !sof_i) |=> (st_q.cnt == $past(st_q.cnt) - cnt_t'(1)));

    // R8
    flag_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(match_o && error_o));
endmodule

// File: rtl/crc16_frame_engine.sv
module crc16_frame_engine
    import crc16_pkg::*;
#(
    parameter crc_t POLY = 16'hA001,
    parameter crc_t INIT = 16'hFFFF
) (
    input  logic        clk_i,
    input  logic        rst_ni,
    input  logic        sof_i,
    input  logic        byte_valid_i,
    input  logic [7:0]  byte_data_i,
    output logic        byte_ready_o,
    input  logic        eof_i,
    input  logic        rx_mode_i,
    output logic [15:0] crc_o,
    output logic [7:0]  chk_first_o,
    output logic [7:0]  chk_second_o,
    output logic        busy_o,
    output logic        done_o,
    output logic        match_o,
    output logic        error_o
);
    logic  accept, busy, zero;
    crc_t  crc;
    byte_t chk_bytes [NBYTES];

    crc16_frame_ctrl u_ctrl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .sof_i      (sof_i),
        .valid_i    (byte_valid_i),
        .eof_i      (eof_i),
        .rx_mode_i  (rx_mode_i),
        .crc_zero_i (zero),
        .ready_o    (byte_ready_o),
        .accept_o   (accept),
        .busy_o     (busy),
        .done_o     (done_o),
        .match_o    (match_o),
        .error_o    (error_o)
    );

    crc16_shift_unit #(.POLY(POLY), .INIT(INIT)) u_shift (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .load_init_i (sof_i),
        .accept_i    (accept),
        .data_i      (byte_data_i),
        .step_en_i   (busy),
        .crc_o       (crc),
        .zero_o      (zero)
    );

    // Check field leaves low byte first.
    for (genvar i = 0; i < NBYTES; i++) begin : g_chk
        assign chk_bytes[i] = crc[i*BYTE_W +: BYTE_W];
    end

    assign crc_o        = crc;
    assign busy_o       = busy;
    assign chk_first_o  = chk_bytes[0];
    assign chk_second_o = chk_bytes[NBYTES-1];

    // R5
    idle_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !sof_i && !(byte_valid_i && byte_ready_o)) |=> $stable(crc_o));

    // R9
    tx_no_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!busy_o && !sof_i && eof_i && !rx_mode_i) |=> (!match_o && !error_o));

    // R10
    eof_busy_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (busy_o && eof_i && !sof_i) |=> !done_o);
endmodule

// File: tb/crc16_frame_engine_test.sv
module crc16_frame_engine_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        sof, valid, eof, rx;
    logic [7:0]  data;
    logic        ready, busy, done, match, err;
    logic [15:0] crc;
    logic [7:0]  c_first, c_second;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    // Behavioural reference state
    int m_crc, m_cnt;
    bit m_done, m_match, m_err;

    always #2.5 clk = ~clk;

    crc16_frame_engine uut (
        .clk_i(clk), .rst_ni(rst_n), .sof_i(sof), .byte_valid_i(valid),
        .byte_data_i(data), .byte_ready_o(ready), .eof_i(eof), .rx_mode_i(rx),
        .crc_o(crc), .chk_first_o(c_first), .chk_second_o(c_second),
        .busy_o(busy), .done_o(done), .match_o(match), .error_o(err)
    );

    task automatic check_val(input string tag, input int act, input int exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic int ref_step(input int c);
        if (c % 2 == 1) return (c / 2) ^ 'hA001;
        return c / 2;
    endfunction

    // Compare last cycle's outcome, drive the next inputs, advance the model.
    task automatic cyc(input bit s, input bit v, input int d, input bit e);
        @(negedge clk);
        check_val("R3 running crc", int'(crc), m_crc);
        check_val("R4 busy", int'(busy), (m_cnt > 0) ? 1 : 0);
        check_val("R8 done", int'(done), int'(m_done));
        check_val("R8 match", int'(match), int'(m_match));
        check_val("R8 error", int'(err), int'(m_err));
        check_val("R7 first byte", int'(c_first), m_crc % 256);
        check_val("R7 second byte", int'(c_second), m_crc / 256);
        sof = s; valid = v; data = 8'(d); eof = e;
        #0;
        check_val("R2 ready", int'(ready), (m_cnt == 0 && !s && !e) ? 1 : 0);
        m_done = 0;
        if (s) begin
            m_crc = 'hFFFF; m_cnt = 0; m_match = 0; m_err = 0;
        end else if (m_cnt > 0) begin
            m_crc = ref_step(m_crc); m_cnt--;
        end else if (e) begin
            m_done = 1;
            m_match = rx && (m_crc == 0);
            m_err = rx && (m_crc != 0);
        end else if (v) begin
            m_crc = ref_step(m_crc ^ (d % 256)); m_cnt = 7;
        end
    endtask

    task automatic send_byte(input int d, input bit hold);
        cyc(0, 1, d, 0);
        for (int k = 0; k < 7; k++) cyc(0, hold, d ^ 'h5A, 0);
    endtask

    task automatic send_str(input string s, input bit hold);
        for (int i = 0; i < s.len(); i++) send_byte(int'(s[i]), hold);
    endtask

    task automatic send_modbus(input int lo, input int hi);
        int fr[6] = '{'h01, 'h03, 'h00, 'h00, 'h00, 'h01};
        foreach (fr[i]) send_byte(fr[i], 0);
        if (lo >= 0) begin
            send_byte(lo, 0);
            send_byte(hi, 0);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            summary();
            $finish;
        end
    end

    initial begin
        rst_n = 0; sof = 0; valid = 0; eof = 0; rx = 0; data = 0;
        m_crc = 'hFFFF; m_cnt = 0; m_done = 0; m_match = 0; m_err = 0;
        repeat (3) @(negedge clk);
        // R11 reset state
        check_val("R11 crc", int'(crc), 'hFFFF);
        check_val("R11 busy", int'(busy), 0);
        check_val("R11 ready", int'(ready), 1);
        check_val("R11 flags", int'({done, match, err}), 0);
        rst_n = 1;

        // R3 single step from preset with 0xFF
        cyc(1, 0, 0, 0);
        cyc(0, 1, 'hFF, 0);
        cyc(0, 0, 0, 0);
        check_val("R3 first step", int'(crc), 'h7F80);
        for (int k = 0; k < 6; k++) cyc(0, 0, 0, 0);
        // R4 after seven cycles the engine is idle again
        cyc(0, 0, 0, 0);
        check_val("R4 idle after 8", int'(busy), 0);

        // R6/R7 known answer, transmit mode
        rx = 0;
        cyc(1, 0, 0, 0);
        send_str("123456789", 0);
        cyc(0, 0, 0, 0);
        check_val("R6 kat", int'(crc), 'h4B37);
        check_val("R7 first", int'(c_first), 'h37);
        check_val("R7 second", int'(c_second), 'h4B);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 0);
        check_val("R9 done", int'(done), 1);
        check_val("R9 no flags", int'({match, err}), 0);

        // R5 valid held high while busy
        cyc(1, 0, 0, 0);
        send_str("123456789", 1);
        cyc(0, 0, 0, 0);
        check_val("R5 kat with held valid", int'(crc), 'h4B37);

        // R6 Modbus frame
        cyc(1, 0, 0, 0);
        send_modbus(-1, 0);
        cyc(0, 0, 0, 0);
        check_val("R6 modbus crc", int'(crc), 'h0A84);
        check_val("R7 modbus first", int'(c_first), 'h84);

        // R8 receive, good frame
        rx = 1;
        cyc(1, 0, 0, 0);
        send_modbus('h84, 'h0A);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 0);
        check_val("R8 match good", int'(match), 1);
        check_val("R8 no error good", int'(err), 0);

        // R8 receive, corrupted check byte
        cyc(1, 0, 0, 0);
        send_modbus('h84, 'h0B);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 0);
        check_val("R8 error bad", int'(err), 1);
        check_val("R8 no match bad", int'(match), 0);
        for (int k = 0; k < 3; k++) cyc(0, 0, 0, 0);
        check_val("R8 error held", int'(err), 1);

        // R1 sof abandons a byte mid-way and clears flags
        cyc(0, 1, 'h31, 0);
        cyc(0, 0, 0, 0);
        cyc(0, 0, 0, 0);
        cyc(1, 0, 0, 0);
        cyc(0, 0, 0, 0);
        check_val("R1 crc preset", int'(crc), 'hFFFF);
        check_val("R1 not busy", int'(busy), 0);
        check_val("R1 flags clear", int'(err), 0);

        // R10 eof while busy ignored
        cyc(0, 1, 'h42, 0);
        cyc(0, 0, 0, 1);
        cyc(0, 0, 0, 0);
        check_val("R10 no done", int'(done), 0);
        check_val("R10 no flags", int'({match, err}), 0);
        for (int k = 0; k < 8; k++) cyc(0, 0, 0, 0);

        finished = 1;
        summary();
        $finish;
    end
endmodule